// File: doc/BRIEF.md
# Triggered Row Buffer with Operating Modes

The block keeps a circular store of incoming sample rows, one row per memory word, and releases parts of it onto a streaming output according to an operating mode chosen through a small register port. In normal acquisition every valid row is written at a free-running write pointer that wraps at the buffer depth. A trigger replays a fixed-length burst of rows that starts a configurable number of rows back in time, so the readout sees the data that arrived one latency period before the trigger. Test mode replays the same way but keeps the store frozen, so the same trigger gives the same data every time.

Three further modes serve set-up and debug. Memory access lets software read and write any word through an address register and a data register. Raw record fills the store and, once triggered, stops after one full buffer of rows, which keeps a snapshot around the trigger. Raw send streams the whole store, from address zero to the last address, once each time the mode is entered. A mode written to the register port waits until any stream in flight has finished, so a burst is never cut short.

Top module: `raw_latency_buffer`

## Requirements
- R1: After reset the output is idle, the mode register reads 0 (memory access), the latency register reads 1, the dropped-trigger count reads 0 and the write pointer is at address 0.
- R2: Register reads return their value on `cfg_rdata` one clock after `cfg_rd`, at addresses 0 (mode, bits 2:0), 1 (latency), 2 (memory address), 3 (memory data at the memory address) and 4 (dropped-trigger count); a latency write above `MAX_LAT` stores `MAX_LAT`, and a mode code above 4 stores 0.
- R3: In memory access mode (code 0) a write to address 3 stores `cfg_wdata[ROW_W-1:0]` at the memory address; such writes are ignored in every other mode, and incoming rows are ignored in this mode.
- R4: In acquisition mode (code 3) each valid row is written at the write pointer, which then advances modulo `DEPTH`; a trigger when the output is idle streams `READ_LEN` rows starting at address (write pointer − latency) modulo `DEPTH`, addresses increasing with wrap, and `out_last` marks the final row.
- R5: Test mode (code 4) reads out on a trigger exactly as R4 but writes no rows and leaves the write pointer unchanged.
- R6: In raw record mode (code 1) rows are written as in R4; a trigger arms a count of rows written from that cycle on, including a row in the same cycle, and after `DEPTH` such rows the memory is frozen and later rows are ignored until the mode changes; triggers produce no output in this mode.
- R7: Entering raw send mode (code 2) streams every address from 0 to `DEPTH-1` once, in order, with `out_last` on the final word; rows are ignored in this mode.
- R8: A new mode takes effect only when no stream is in progress; while a stream runs the previous mode stays active.
- R9: A trigger in acquisition or test mode that arrives while a stream is in progress is not queued; it increments the dropped-trigger count, which wraps.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| row_valid | input | 1 | A row is present on `row_data` this cycle |
| row_data | input | ROW_W | Incoming row |
| trig_in | input | 1 | Trigger pulse |
| cfg_we | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, valid one clock after `cfg_rd` |
| out_valid | output | 1 | Output row valid |
| out_ready | input | 1 | Sink accepts the output row |
| out_data | output | ROW_W | Output row |
| out_last | output | 1 | Final row of a burst or dump |

## Verification
The properties assume that the sink may hold `out_ready` low for any time, that triggers are single-cycle or back-to-back pulses, and that no trigger coincides with the cycle in which a queued mode change is applied. The stimulus keeps to this by changing modes only from the register port while no trigger is driven and by giving a latency no smaller than the burst length, so an acquisition burst never reads a word being written. Output backpressure follows a fixed duty pattern during the dump and the wrapping burst, which exercises the holding rule without breaking the sink assumption.

// File: rtl/raw_buf_pkg.sv
package raw_buf_pkg;

  typedef enum logic [2:0] {
    MODE_MEMACC = 3'd0,
    MODE_RECORD = 3'd1,
    MODE_SEND   = 3'd2,
    MODE_ACQ    = 3'd3,
    MODE_TEST   = 3'd4
  } op_mode_e;

  localparam logic [2:0] RA_MODE  = 3'd0;
  localparam logic [2:0] RA_LAT   = 3'd1;
  localparam logic [2:0] RA_MADDR = 3'd2;
  localparam logic [2:0] RA_MDATA = 3'd3;
  localparam logic [2:0] RA_DROPS = 3'd4;

endpackage

// File: rtl/raw_cfg_regs.sv
module raw_cfg_regs
  import raw_buf_pkg::*;
#(
  parameter int ROW_W   = 16,
  parameter int ADDR_W  = 11,
  parameter int LAT_W   = 11,
  parameter int MAX_LAT = 1024,
  parameter int DROP_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_rd,
  input  logic [2:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  op_mode_e          mode_act,
  input  logic [ROW_W-1:0]  mem_rdata,
  input  logic [DROP_W-1:0] drop_cnt,
  output op_mode_e          mode_pend,
  output logic [LAT_W-1:0]  lat,
  output logic [ADDR_W-1:0] maddr,
  output logic              mem_we,
  output logic [31:0]       cfg_rdata
);

  logic        mode_en, lat_en, maddr_en;
  op_mode_e    mode_nxt;
  logic [LAT_W-1:0] lat_nxt;
  logic [31:0] rdata_nxt;

  always_comb begin
    mode_en  = cfg_we && (cfg_addr == RA_MODE);
    lat_en   = cfg_we && (cfg_addr == RA_LAT);
    maddr_en = cfg_we && (cfg_addr == RA_MADDR);
    mem_we   = cfg_we && (cfg_addr == RA_MDATA) && (mode_act == MODE_MEMACC);

    mode_nxt = (cfg_wdata[2:0] > 3'd4) ? MODE_MEMACC : op_mode_e'(cfg_wdata[2:0]);
    lat_nxt  = (cfg_wdata > 32'(MAX_LAT)) ? LAT_W'(MAX_LAT) : cfg_wdata[LAT_W-1:0];

    rdata_nxt = '0;
    case (cfg_addr)
      RA_MODE:  rdata_nxt[2:0]        = mode_pend;
      RA_LAT:   rdata_nxt[LAT_W-1:0]  = lat;
      RA_MADDR: rdata_nxt[ADDR_W-1:0] = maddr;
      RA_MDATA: rdata_nxt[ROW_W-1:0]  = mem_rdata;
      RA_DROPS: rdata_nxt[DROP_W-1:0] = drop_cnt;
      default:  rdata_nxt = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_pend <= MODE_MEMACC;
      lat       <= LAT_W'(1);
      maddr     <= '0;
      cfg_rdata <= '0;
    end else begin
      if (mode_en)  mode_pend <= mode_nxt;
      if (lat_en)   lat       <= lat_nxt;
      if (maddr_en) maddr     <= cfg_wdata[ADDR_W-1:0];
      if (cfg_rd)   cfg_rdata <= rdata_nxt;
    end
  end

endmodule

// File: rtl/raw_row_mem.sv
module raw_row_mem #(
  parameter int ROW_W  = 16,
  parameter int DEPTH  = 2048,
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [ROW_W-1:0]  wdata,
  input  logic [ADDR_W-1:0] raddr_a,
  output logic [ROW_W-1:0]  rdata_a,
  input  logic [ADDR_W-1:0] raddr_b,
  output logic [ROW_W-1:0]  rdata_b
);

  logic [ROW_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata_a = store[raddr_a];
  assign rdata_b = store[raddr_b];

endmodule

// File: rtl/raw_wr_ctrl.sv
module raw_wr_ctrl
  import raw_buf_pkg::*;
#(
  parameter int DEPTH  = 2048,
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  op_mode_e          mode_act,
  input  logic              mode_upd,
  input  logic              row_valid,
  input  logic              trig_in,
  output logic              row_we,
  output logic [ADDR_W-1:0] wr_ptr,
  output logic              frozen
);

  localparam int CNT_W = ADDR_W + 1;

  logic             armed, armed_nxt, frozen_nxt, counting;
  logic [CNT_W-1:0] post_cnt, cnt_nxt, cnt_base;
  logic [ADDR_W-1:0] ptr_nxt;

  always_comb begin
    row_we   = row_valid && ((mode_act == MODE_ACQ) ||
                             ((mode_act == MODE_RECORD) && !frozen));
    counting = (mode_act == MODE_RECORD) && (armed || trig_in);
    cnt_base = armed ? post_cnt : '0;
    ptr_nxt  = row_we ? wr_ptr + ADDR_W'(1) : wr_ptr;

    armed_nxt  = armed;
    cnt_nxt    = post_cnt;
    frozen_nxt = frozen;
    if (mode_upd) begin
      armed_nxt  = 1'b0;
      cnt_nxt    = '0;
      frozen_nxt = 1'b0;
    end else if (counting && !frozen) begin
      armed_nxt = 1'b1;
      cnt_nxt   = cnt_base;
      if (row_we) begin
        cnt_nxt = cnt_base + CNT_W'(1);
        if (cnt_base + CNT_W'(1) == CNT_W'(DEPTH)) frozen_nxt = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      armed    <= 1'b0;
      post_cnt <= '0;
      frozen   <= 1'b0;
    end else begin
      wr_ptr   <= ptr_nxt;
      armed    <= armed_nxt;
      post_cnt <= cnt_nxt;
      frozen   <= frozen_nxt;
    end
  end

endmodule

// File: rtl/raw_rd_engine.sv
module raw_rd_engine #(
  parameter int ROW_W    = 16,
  parameter int DEPTH    = 2048,
  parameter int ADDR_W   = 11,
  parameter int READ_LEN = 8,
  parameter int DROP_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_dump,
  input  logic              start_trig,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [ROW_W-1:0]  mem_rdata,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] rd_ptr,
  output logic              busy,
  output logic              out_valid,
  output logic [ROW_W-1:0]  out_data,
  output logic              out_last,
  output logic [DROP_W-1:0] drop_cnt
);

  localparam int CNT_W = ADDR_W + 1;

  logic [CNT_W-1:0]  left, left_nxt;
  logic [ADDR_W-1:0] ptr_nxt;
  logic              ov_nxt, ol_nxt, load, drop;
  logic [ROW_W-1:0]  od_nxt;

  always_comb begin
    busy     = (left != '0) || out_valid;
    load     = (left != '0) && (!out_valid || out_ready);
    drop     = start_trig && busy;
    left_nxt = left;
    ptr_nxt  = rd_ptr;
    ov_nxt   = out_valid;
    ol_nxt   = out_last;
    od_nxt   = out_data;
    if (load) begin
      od_nxt   = mem_rdata;
      ov_nxt   = 1'b1;
      ol_nxt   = (left == CNT_W'(1));
      ptr_nxt  = rd_ptr + ADDR_W'(1);
      left_nxt = left - CNT_W'(1);
    end else if (out_valid && out_ready) begin
      ov_nxt = 1'b0;
      ol_nxt = 1'b0;
    end
    if (!busy) begin
      if (start_dump) begin
        left_nxt = CNT_W'(DEPTH);
        ptr_nxt  = '0;
      end else if (start_trig) begin
        left_nxt = CNT_W'(READ_LEN);
        ptr_nxt  = start_addr;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left      <= '0;
      rd_ptr    <= '0;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      out_data  <= '0;
      drop_cnt  <= '0;
    end else begin
      left      <= left_nxt;
      rd_ptr    <= ptr_nxt;
      out_valid <= ov_nxt;
      out_last  <= ol_nxt;
      if (load) out_data <= od_nxt;
      if (drop) drop_cnt <= drop_cnt + DROP_W'(1);
    end
  end

endmodule

// File: rtl/raw_latency_buffer.sv
module raw_latency_buffer
  import raw_buf_pkg::*;
#(
  parameter int ROW_W    = 16,
  parameter int DEPTH    = 2048,
  parameter int MAX_LAT  = 1024,
  parameter int READ_LEN = 8,
  parameter int DROP_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             row_valid,
  input  logic [ROW_W-1:0] row_data,
  input  logic             trig_in,
  input  logic             cfg_we,
  input  logic             cfg_rd,
  input  logic [2:0]       cfg_addr,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      cfg_rdata,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [ROW_W-1:0] out_data,
  output logic             out_last
);

  localparam int ADDR_W = $clog2(DEPTH);
  localparam int LAT_W  = $clog2(MAX_LAT + 1);

  logic [1:0]        rst_sync;
  logic              srst_n;
  op_mode_e          mode_act, mode_pend;
  logic              mode_upd, busy, frozen;
  logic [LAT_W-1:0]  lat;
  logic [ADDR_W-1:0] maddr, wr_ptr, rd_ptr, start_addr;
  logic [ADDR_W:0]   diff, lat_ext;
  logic              cfg_mem_we, row_we, mem_we, start_dump, start_trig;
  logic [ADDR_W-1:0] mem_waddr;
  logic [ROW_W-1:0]  mem_wdata, eng_rdata, cfg_mdata;
  logic [DROP_W-1:0] drop_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign srst_n = rst_sync[1];

  always_comb begin
    mode_upd   = !busy && (mode_pend != mode_act);
    start_dump = mode_upd && (mode_pend == MODE_SEND);
    start_trig = trig_in && ((mode_act == MODE_ACQ) || (mode_act == MODE_TEST));
    lat_ext    = '0;
    lat_ext[LAT_W-1:0] = lat;
    diff       = {1'b0, wr_ptr} - lat_ext;
    start_addr = diff[ADDR_W-1:0];
    mem_we     = cfg_mem_we || row_we;
    mem_waddr  = cfg_mem_we ? maddr : wr_ptr;
    mem_wdata  = cfg_mem_we ? cfg_wdata[ROW_W-1:0] : row_data;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)       mode_act <= MODE_MEMACC;
    else if (mode_upd) mode_act <= mode_pend;
  end

  raw_cfg_regs #(
    .ROW_W(ROW_W), .ADDR_W(ADDR_W), .LAT_W(LAT_W),
    .MAX_LAT(MAX_LAT), .DROP_W(DROP_W)
  ) u_regs (
    .clk(clk), .rst_n(srst_n), .cfg_we(cfg_we), .cfg_rd(cfg_rd),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .mode_act(mode_act),
    .mem_rdata(cfg_mdata), .drop_cnt(drop_cnt), .mode_pend(mode_pend),
    .lat(lat), .maddr(maddr), .mem_we(cfg_mem_we), .cfg_rdata(cfg_rdata)
  );

  raw_row_mem #(.ROW_W(ROW_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr_a(rd_ptr), .rdata_a(eng_rdata),
    .raddr_b(maddr), .rdata_b(cfg_mdata)
  );

  raw_wr_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_wr (
    .clk(clk), .rst_n(srst_n), .mode_act(mode_act), .mode_upd(mode_upd),
    .row_valid(row_valid), .trig_in(trig_in), .row_we(row_we),
    .wr_ptr(wr_ptr), .frozen(frozen)
  );

  raw_rd_engine #(
    .ROW_W(ROW_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W),
    .READ_LEN(READ_LEN), .DROP_W(DROP_W)
  ) u_rd (
    .clk(clk), .rst_n(srst_n), .start_dump(start_dump), .start_trig(start_trig),
    .start_addr(start_addr), .mem_rdata(eng_rdata), .out_ready(out_ready),
    .rd_ptr(rd_ptr), .busy(busy), .out_valid(out_valid), .out_data(out_data),
    .out_last(out_last), .drop_cnt(drop_cnt)
  );

endmodule

// File: rtl/raw_buf_chk.sv
module raw_buf_chk
  import raw_buf_pkg::*;
#(
  parameter int ROW_W  = 16,
  parameter int DROP_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input op_mode_e          mode_act,
  input logic              mem_we,
  input logic              frozen,
  input logic              busy,
  input logic              trig_in,
  input logic              out_valid,
  input logic              out_ready,
  input logic [ROW_W-1:0]  out_data,
  input logic              out_last,
  input logic [DROP_W-1:0] drop_cnt
);

  // R10: stalled output holds
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  // R4: last marker only on a valid row
  p_last_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  // R5: test mode never writes
  p_test_nowrite_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_act == MODE_TEST) |-> !mem_we);

  // R6: frozen store never written
  p_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |-> !mem_we);

  // R8: mode stays while a stream runs
  p_mode_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (mode_act == $past(mode_act)));

  // R9: busy trigger counted
  p_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_in && busy && (mode_act == MODE_ACQ || mode_act == MODE_TEST))
      |=> (drop_cnt == $past(drop_cnt) + DROP_W'(1)));

endmodule

bind raw_latency_buffer raw_buf_chk #(.ROW_W(ROW_W), .DROP_W(DROP_W)) u_chk (
  .clk(clk), .rst_n(srst_n), .mode_act(mode_act), .mem_we(mem_we),
  .frozen(frozen), .busy(busy), .trig_in(trig_in), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
  .drop_cnt(drop_cnt)
);

// File: tb/raw_latency_buffer_tb_top.sv
module raw_latency_buffer_tb_top;

  localparam int ROW_W    = 16;
  localparam int DEPTH    = 64;
  localparam int MAX_LAT  = 32;
  localparam int READ_LEN = 4;
  localparam int DROP_W   = 8;

  logic             clk;
  logic             rst_n;
  logic             row_valid;
  logic [ROW_W-1:0] row_data;
  logic             trig_in;
  logic             cfg_we, cfg_rd;
  logic [2:0]       cfg_addr;
  logic [31:0]      cfg_wdata, cfg_rdata;
  logic             out_valid, out_ready, out_last;
  logic [ROW_W-1:0] out_data;

  int n_checks = 0;
  int n_fails  = 0;
  bit bp_en    = 1'b0;
  bit finished = 1'b0;

  logic [ROW_W:0] exp_q [$];
  string          tag_q [$];
  logic [ROW_W-1:0] model [DEPTH];
  int wp = 0;

  raw_latency_buffer #(
    .ROW_W(ROW_W), .DEPTH(DEPTH), .MAX_LAT(MAX_LAT),
    .READ_LEN(READ_LEN), .DROP_W(DROP_W)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .row_valid(row_valid), .row_data(row_data),
    .trig_in(trig_in), .cfg_we(cfg_we), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every accepted row
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R4 unexpected row", {15'd0, out_last, out_data}, 32'd0);
      end else begin
        logic [ROW_W:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({out_last, out_data} == e, t, {15'd0, out_last, out_data}, {15'd0, e});
      end
    end
  end

  // sink readiness pattern
  initial begin
    int ph = 0;
    out_ready = 1'b1;
    forever begin
      @(posedge clk); #1;
      ph++;
      out_ready = bp_en ? (ph % 3 != 0) : 1'b1;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic cfg_write(input logic [2:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input logic [2:0] a, output logic [31:0] v);
    cfg_rd = 1'b1; cfg_addr = a;
    @(posedge clk); #1;
    cfg_rd = 1'b0;
    v = cfg_rdata;
  endtask

  task automatic push_row(input logic [ROW_W-1:0] d, input bit trg);
    row_valid = 1'b1; row_data = d; trig_in = trg;
    @(posedge clk); #1;
    row_valid = 1'b0; trig_in = 1'b0;
  endtask

  task automatic expect_burst(input int lat, input string t);
    for (int k = 0; k < READ_LEN; k++) begin
      int a;
      a = ((wp - lat + k) % DEPTH + DEPTH) % DEPTH;
      exp_q.push_back({(k == READ_LEN - 1), model[a]});
      tag_q.push_back(t);
    end
  endtask

  task automatic wait_drain();
    for (int i = 0; i < 3000 && exp_q.size() != 0; i++) begin @(posedge clk); #1; end
    idle(4);
    check(exp_q.size() == 0, "R4 scoreboard drained", exp_q.size(), 0);
  endtask

  task automatic set_mode(input logic [2:0] m);
    cfg_write(3'd0, {29'd0, m});
    idle(2);
  endtask

  initial begin
    #(8 * 100000);
    if (!finished) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; row_valid = 1'b0; row_data = '0; trig_in = 1'b0;
    cfg_we = 1'b0; cfg_rd = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    idle(4);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    check(out_valid == 1'b0, "R1 out_valid", {31'd0, out_valid}, 0);
    cfg_read(3'd0, v); check(v == 0, "R1 mode", v, 0);
    cfg_read(3'd1, v); check(v == 1, "R1 latency", v, 1);
    cfg_read(3'd4, v); check(v == 0, "R1 drops", v, 0);

    // R2 clamp and readback, R3 memory access
    cfg_write(3'd1, 32'd100);
    cfg_read(3'd1, v); check(v == MAX_LAT, "R2 latency clamp", v, MAX_LAT);
    cfg_write(3'd2, 32'd5);
    cfg_read(3'd2, v); check(v == 5, "R2 address readback", v, 5);
    cfg_write(3'd3, 32'h0000_ABCD);
    cfg_read(3'd3, v); check(v == 32'hABCD, "R3 data readback", v, 32'hABCD);
    push_row(16'hEEEE, 1'b0);       // ignored in memory access (R3)
    for (int a = 0; a < DEPTH; a++) begin
      model[a] = 16'(a * 3 + 16'h100);
      cfg_write(3'd2, a);
      cfg_write(3'd3, {16'd0, model[a]});
    end
    cfg_write(3'd2, 32'd7);
    cfg_read(3'd3, v); check(v == model[7], "R3 fill readback", v, {16'd0, model[7]});

    // R7 dump with backpressure; R8 mode queued during it
    bp_en = 1'b1;
    for (int a = 0; a < DEPTH; a++) begin
      exp_q.push_back({(a == DEPTH - 1), model[a]});
      tag_q.push_back("R7 dump");
    end
    set_mode(3'd2);
    push_row(16'h1111, 1'b0);       // ignored in send mode (R7)
    cfg_write(3'd0, 32'd3);         // R8: pending until dump ends
    push_row(16'h2222, 1'b0);       // still send mode: ignored (R8)
    push_row(16'h3333, 1'b0);
    wait_drain();
    bp_en = 1'b0;
    cfg_read(3'd0, v); check(v == 3, "R2 mode readback", v, 3);

    // R4 acquisition, R9 dropped trigger
    cfg_write(3'd1, 32'd10);
    for (int i = 0; i < 20; i++) begin
      push_row(16'(16'h2000 + i), 1'b0);
      model[wp % DEPTH] = 16'(16'h2000 + i); wp = (wp + 1) % DEPTH;
    end
    expect_burst(10, "R4 acq burst (R8 rows ignored)");
    trig_in = 1'b1; idle(2); trig_in = 1'b0;   // second cycle is dropped (R9)
    wait_drain();
    cfg_read(3'd4, v); check(v == 1, "R9 drop count", v, 1);

    // R4 wrap inside a burst
    for (int i = 0; i < 50; i++) begin
      push_row(16'(16'h3000 + i), 1'b0);
      model[wp % DEPTH] = 16'(16'h3000 + i); wp = (wp + 1) % DEPTH;
    end
    cfg_write(3'd1, 32'd8);
    bp_en = 1'b1;
    expect_burst(8, "R4 wrapped burst");
    trig_in = 1'b1; idle(1); trig_in = 1'b0;
    wait_drain();
    bp_en = 1'b0;

    // R5 test mode, R3 data write ignored outside memory access
    set_mode(3'd4);
    for (int i = 0; i < 5; i++) push_row(16'(16'h4000 + i), 1'b0);
    cfg_write(3'd2, 32'd4);
    cfg_write(3'd3, 32'h0000_DEAD);
    cfg_write(3'd1, 32'd3);
    expect_burst(3, "R5 test burst, R3 ignored write");
    trig_in = 1'b1; idle(1); trig_in = 1'b0;
    wait_drain();

    // R6 record and freeze
    set_mode(3'd1);
    for (int i = 0; i < 5; i++) begin
      push_row(16'(16'h5000 + i), 1'b0);
      model[wp % DEPTH] = 16'(16'h5000 + i); wp = (wp + 1) % DEPTH;
    end
    begin
      int t0;
      t0 = wp;
      for (int i = 0; i < DEPTH; i++) begin
        push_row(16'(16'h6000 + i), (i == 0));
        model[wp % DEPTH] = 16'(16'h6000 + i); wp = (wp + 1) % DEPTH;
      end
      for (int i = 0; i < 4; i++) push_row(16'(16'h7000 + i), 1'b0);
      trig_in = 1'b1; idle(1); trig_in = 1'b0;   // no output in record (R6)
      idle(4);
      set_mode(3'd0);
      for (int k = 0; k < 4; k++) begin
        cfg_write(3'd2, (t0 + k) % DEPTH);
        cfg_read(3'd3, v);
        check(v == model[(t0 + k) % DEPTH], "R6 frozen snapshot", v,
              {16'd0, model[(t0 + k) % DEPTH]});
      end
      cfg_write(3'd2, (t0 + DEPTH - 1) % DEPTH);
      cfg_read(3'd3, v);
      check(v == model[(t0 + DEPTH - 1) % DEPTH], "R6 last recorded row", v,
            {16'd0, model[(t0 + DEPTH - 1) % DEPTH]});
    end
    check(exp_q.size() == 0 && out_valid == 1'b0, "R6 no output", {31'd0, out_valid}, 0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

endmodule